// File: doc/BRIEF.md
# Strobe-Decoded DRAM Core with Parallel Compare Test Mode

This block is the device-side logic of a x1 dynamic memory. It watches the active-low row strobe, column strobe and write strobe. From the order in which they fall it decides what each memory cycle is: a normal access, a refresh that uses only the row strobe, or a refresh where the column strobe falls first. The strobes are asynchronous to the block. Each one passes through a two-flop synchronizer clocked by a fast local clock. The cycle type is decided on the first synchronized falling edge.

The storage is eight sectors of equal depth that share one word index. In normal mode, three address bits pick one sector, so the array behaves as a x1 memory. Those bits are the top row bit, the top column bit and the lowest column bit. A column-first refresh with the write strobe low switches the block into a compressed test mode. In that mode, a write stores the data bit in all eight sectors at once. A read returns 1 when all eight stored bits agree and 0 when any of them differs. Any other refresh returns the block to normal mode. The output carries its own enable for an external tri-state pad.

Top module: `tm_dram_core`

## Requirements
- R1: After reset the output enable `dq_oe` is 0, the output bit is 0, and the block is in normal mode.
- R2: In normal mode, row bit AW-1, column bit AW-1 and column bit 0 form the sector number {row[AW-1], col[AW-1], col[0]}. A write stores DI in that sector only, at the word index {row[AW-2:0], col[AW-2:1]}. A later read at the same address returns the stored bit.
- R3: In a cycle where the write strobe is low when the column strobe falls (early write), `dq_oe` stays 0 for the whole cycle.
- R4: In a read cycle, `dq_oe` rises while the column strobe is still low and shows the addressed bit. It returns to 0 within three clocks after the synchronized column strobe rises.
- R5: When the column strobe falls before the row strobe while the write strobe is low, the block enters test mode.
- R6: In test mode, a write stores DI in all eight sectors at the addressed word index.
- R7: In test mode, a read returns 1 if the eight sector bits at the word index are all equal, and 0 otherwise.
- R8: In test mode, the three sector-select bits have no effect: addresses that differ only in those bits reach the same word.
- R9: A column-first refresh with the write strobe high leaves test mode.
- R10: A row-only refresh leaves test mode, and it changes no stored data. A row-only refresh is a row strobe pulse with no column strobe fall while the row strobe is low.
- R11: Several column strobe pulses under one row strobe low period (page mode) all use the row address latched when the row strobe fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | AW | Multiplexed row/column address |
| di | input | 1 | Write data bit |
| dq_out | output | 1 | Registered read data or compare result |
| dq_oe | output | 1 | Output enable for the data pad |

## Verification
The assertions assume that each strobe is held for several sampling clocks, so that no two strobes change in the same synchronized cycle. They also assume that the write strobe is steady for the whole of a column strobe low period, and that address and DI are stable by the time the synchronized strobe edge is acted on. The bench keeps to these assumptions. It changes one strobe at a time on the falling clock edge and waits at least five clocks after each change. It sets address, DI and the write strobe together with the strobe they belong to and holds them until that strobe is released. It also keeps every column strobe low for eight clocks, so the two-stage read pipeline finishes before the strobe rises.

// File: rtl/tm_dram_pkg.sv
package tm_dram_pkg;
  localparam int NSEC  = 8;
  localparam int SEC_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE,   // row strobe inactive
    ST_ROW,    // row open, waiting for column strobe
    ST_COL,    // column strobe active within an access
    ST_REFR    // column-first refresh in progress
  } cyc_state_e;
endpackage

// File: rtl/tm_strobe_sync.sv
module tm_strobe_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b1;
        stab_q <= 1'b1;
      end else begin
        meta_q <= async_in[i];
        stab_q <= meta_q;
      end
    end
    assign lvl[i] = stab_q;
  end
endmodule

// File: rtl/tm_sector_array.sv
module tm_sector_array #(
  parameter int NSEC  = 8,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic [NSEC-1:0]  wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [NSEC-1:0]  rd_word
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic cell_q [DEPTH];
    logic rbit_q;
    always_ff @(posedge clk) begin
      if (wr_en[s]) cell_q[wr_idx] <= wr_bit;
      rbit_q <= cell_q[rd_idx];
    end
    assign rd_word[s] = rbit_q;
  end
endmodule

// File: rtl/tm_cycle_ctrl.sv
module tm_cycle_ctrl
  import tm_dram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int IDX_W = 2 * AW - 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_fall,
  input  logic             ras_rise,
  input  logic             cas_lvl,
  input  logic             cas_fall,
  input  logic             cas_rise,
  input  logic             we_lvl,
  input  logic [AW-1:0]    addr,
  input  logic             di,
  output logic             tm_mode,
  output logic [NSEC-1:0]  sec_we,
  output logic [IDX_W-1:0] widx,
  output logic             wbit,
  output logic [IDX_W-1:0] ridx,
  output logic             rd_go,
  output logic [SEC_W-1:0] rd_sec,
  output logic             rd_cmp
);
  cyc_state_e       st_q;
  logic [AW-1:0]    row_q;
  logic             had_col_q;
  logic [SEC_W-1:0] col_sec;
  logic [IDX_W-1:0] col_idx;

  assign col_sec = {row_q[AW-1], addr[AW-1], addr[0]};
  assign col_idx = {row_q[AW-2:0], addr[AW-2:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      tm_mode   <= 1'b0;
      row_q     <= '0;
      had_col_q <= 1'b0;
      sec_we    <= '0;
      widx      <= '0;
      wbit      <= 1'b0;
      ridx      <= '0;
      rd_go     <= 1'b0;
      rd_sec    <= '0;
      rd_cmp    <= 1'b0;
    end else begin
      sec_we <= '0;
      rd_go  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (ras_fall) begin
          if (cas_lvl) begin
            row_q     <= addr;
            had_col_q <= 1'b0;
            st_q      <= ST_ROW;
          end else begin
            tm_mode <= ~we_lvl;
            st_q    <= ST_REFR;
          end
        end
        ST_ROW: begin
          if (ras_rise) begin
            if (!had_col_q) tm_mode <= 1'b0;
            st_q <= ST_IDLE;
          end else if (cas_fall) begin
            had_col_q <= 1'b1;
            st_q      <= ST_COL;
            if (!we_lvl) begin
              sec_we <= tm_mode ? {NSEC{1'b1}} : (NSEC'(1) << col_sec);
              widx   <= col_idx;
              wbit   <= di;
            end else begin
              rd_go  <= 1'b1;
              ridx   <= col_idx;
              rd_sec <= col_sec;
              rd_cmp <= tm_mode;
            end
          end
        end
        ST_COL: begin
          if (ras_rise)      st_q <= ST_IDLE;
          else if (cas_rise) st_q <= ST_ROW;
        end
        default: if (ras_rise) st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tm_dram_core.sv
module tm_dram_core
  import tm_dram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          di,
  output logic          dq_out,
  output logic          dq_oe
);
  localparam int IDX_W = 2 * AW - 3;

  logic [2:0]       s_lvl;
  logic             ras_s, cas_s, we_s;
  logic             ras_d, cas_d;
  logic             ras_fall, ras_rise, cas_fall, cas_rise;
  logic             tm_mode;
  logic [NSEC-1:0]  sec_we;
  logic [IDX_W-1:0] widx, ridx;
  logic             wbit, rd_go, rd_cmp, rd_v_q;
  logic [SEC_W-1:0] rd_sec;
  logic [NSEC-1:0]  rd_word;

  tm_strobe_sync #(.W(3)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({we_n, cas_n, ras_n}),
    .lvl(s_lvl)
  );
  assign ras_s = s_lvl[0];
  assign cas_s = s_lvl[1];
  assign we_s  = s_lvl[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_d <= 1'b1;
      cas_d <= 1'b1;
    end else begin
      ras_d <= ras_s;
      cas_d <= cas_s;
    end
  end
  assign ras_fall = ras_d & ~ras_s;
  assign ras_rise = ~ras_d & ras_s;
  assign cas_fall = cas_d & ~cas_s;
  assign cas_rise = ~cas_d & cas_s;

  tm_cycle_ctrl #(.AW(AW), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_lvl(cas_s), .cas_fall(cas_fall), .cas_rise(cas_rise),
    .we_lvl(we_s), .addr(addr), .di(di),
    .tm_mode(tm_mode), .sec_we(sec_we), .widx(widx), .wbit(wbit),
    .ridx(ridx), .rd_go(rd_go), .rd_sec(rd_sec), .rd_cmp(rd_cmp)
  );

  tm_sector_array #(.NSEC(NSEC), .IDX_W(IDX_W)) u_array (
    .clk(clk), .wr_en(sec_we), .wr_idx(widx), .wr_bit(wbit),
    .rd_idx(ridx), .rd_word(rd_word)
  );

  // Output stage: data valid one clock after the array read.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v_q <= 1'b0;
      dq_out <= 1'b0;
      dq_oe  <= 1'b0;
    end else begin
      rd_v_q <= rd_go;
      if (cas_rise) begin
        dq_oe <= 1'b0;
      end else if (rd_v_q && !cas_s) begin
        dq_out <= rd_cmp ? ((&rd_word) | ~(|rd_word)) : rd_word[rd_sec];
        dq_oe  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tm_dram_core_chk.sv
module tm_dram_core_chk #(
  parameter int NSEC = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic            dq_oe,
  input logic            tm_q,
  input logic [NSEC-1:0] wr_en
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!dq_oe && !tm_q));

  // R3
  early_write_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> we_n);

  // R4
  oe_under_cas_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> !cas_n);

  // R4
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    (cas_n && $past(cas_n) && $past(cas_n, 2) && $past(cas_n, 3)) |-> !dq_oe);

  // R5
  tm_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tm_q) |-> (!we_n && !cas_n && !ras_n));

  // R9 and R10
  tm_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tm_q) |-> we_n);

  // R2
  normal_one_sector_chk: assert property (@(posedge clk) disable iff (rst)
    !tm_q |-> $onehot0(wr_en));

  // R6
  test_all_sectors_chk: assert property (@(posedge clk) disable iff (rst)
    (tm_q && (wr_en != '0)) |-> (&wr_en));
endmodule

bind tm_dram_core tm_dram_core_chk #(.NSEC(tm_dram_pkg::NSEC)) u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .dq_oe(dq_oe), .tm_q(tm_mode), .wr_en(sec_we)
);

// File: tb/tm_dram_core_tb.sv
module tm_dram_core_tb_top;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, di = 1'b0;
  logic [AW-1:0] addr = '0;
  logic dq_out, dq_oe;
  int   total = 0, bad = 0;
  bit   done = 0;

  localparam logic [7:0] PAT = 8'b1011_0010;

  always #5 clk = ~clk;

  tm_dram_core #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .di(di), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mkrow(input int sec, input int rlow);
    logic [2:0] s = 3'(sec);
    return {s[2], 5'(rlow)};
  endfunction

  function automatic logic [AW-1:0] mkcol(input int sec, input int clow);
    logic [2:0] s = 3'(sec);
    return {s[1], 4'(clow), s[0]};
  endfunction

  task automatic ras_open(input logic [AW-1:0] r);
    addr = r; ras_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic ras_close;
    ras_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cas_pulse(input logic [AW-1:0] c, input logic wr, input logic d,
                           output logic q, output logic oe_any);
    addr = c; di = d; we_n = ~wr; cas_n = 1'b0; oe_any = 1'b0;
    repeat (8) begin
      @(negedge clk);
      oe_any |= dq_oe;
    end
    q = dq_out;
    cas_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(dq_oe == 1'b0, "R4 enable released after CAS", dq_oe, 0);
    we_n = 1'b1;
  endtask

  task automatic do_write(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic d);
    logic q, oe;
    ras_open(r);
    cas_pulse(c, 1'b1, d, q, oe);
    chk(oe == 1'b0, "R3 early write keeps output off", oe, 0);
    ras_close();
  endtask

  task automatic do_read(input logic [AW-1:0] r, input logic [AW-1:0] c, output logic q);
    logic oe;
    ras_open(r);
    cas_pulse(c, 1'b0, 1'b0, q, oe);
    chk(oe == 1'b1, "R4 read drives output", oe, 1);
    ras_close();
  endtask

  task automatic cbr(input logic we_low);
    we_n = ~we_low; cas_n = 1'b0;
    repeat (6) @(negedge clk);
    ras_n = 1'b0;
    repeat (6) @(negedge clk);
    ras_n = 1'b1;
    repeat (6) @(negedge clk);
    cas_n = 1'b1; we_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic ras_only(input logic [AW-1:0] r);
    ras_open(r);
    ras_close();
  endtask

  task automatic t_reset;
    chk(dq_oe == 1'b0, "R1 enable after reset", dq_oe, 0);
    chk(dq_out == 1'b0, "R1 data after reset", dq_out, 0);
  endtask

  task automatic t_normal;
    logic q;
    for (int s = 0; s < 8; s++) do_write(mkrow(s, 5'h0A), mkcol(s, 4'h3), PAT[s]);
    for (int s = 0; s < 8; s++) begin
      do_read(mkrow(s, 5'h0A), mkcol(s, 4'h3), q);
      chk(q == PAT[s], "R2 sector bit readback", q, PAT[s]);
    end
    do_write(mkrow(0, 5'h15), mkcol(0, 4'hC), 1'b1);
    do_read(mkrow(0, 5'h0A), mkcol(0, 4'h3), q);
    chk(q == PAT[0], "R2 other index untouched", q, PAT[0]);
    do_read(mkrow(0, 5'h15), mkcol(0, 4'hC), q);
    chk(q == 1'b1, "R2 second index", q, 1);
  endtask

  task automatic t_page;
    logic q, oe;
    ras_open(mkrow(3, 5'h07));
    cas_pulse(mkcol(3, 4'h1), 1'b1, 1'b1, q, oe);
    cas_pulse(mkcol(3, 4'h2), 1'b1, 1'b0, q, oe);
    cas_pulse(mkcol(3, 4'h1), 1'b0, 1'b0, q, oe);
    chk(q == 1'b1 && oe, "R11 page read col 1", q, 1);
    cas_pulse(mkcol(3, 4'h2), 1'b0, 1'b0, q, oe);
    chk(q == 1'b0 && oe, "R11 page read col 2", q, 0);
    ras_close();
    do_read(mkrow(3, 5'h07), mkcol(3, 4'h1), q);
    chk(q == 1'b1, "R11 page write landed on latched row", q, 1);
  endtask

  task automatic t_test_mode;
    logic q;
    cbr(1'b1);
    do_read(mkrow(1, 5'h0A), mkcol(1, 4'h3), q);
    chk(q == 1'b0, "R5 R7 mixed word compares 0", q, 0);
    do_write(mkrow(7, 5'h11), mkcol(7, 4'h5), 1'b1);
    do_read(mkrow(2, 5'h11), mkcol(2, 4'h5), q);
    chk(q == 1'b1, "R7 R8 equal word compares 1", q, 1);
    do_write(mkrow(2, 5'h11), mkcol(5, 4'h5), 1'b0);
    do_read(mkrow(6, 5'h11), mkcol(6, 4'h5), q);
    chk(q == 1'b1, "R8 rewrite via other select bits", q, 1);
    do_write(mkrow(4, 5'h12), mkcol(4, 4'h6), 1'b1);
    cbr(1'b0);
    do_read(mkrow(1, 5'h0A), mkcol(1, 4'h3), q);
    chk(q == PAT[1], "R9 normal read after exit", q, PAT[1]);
    for (int s = 0; s < 8; s++) begin
      do_read(mkrow(s, 5'h12), mkcol(s, 4'h6), q);
      chk(q == 1'b1, "R6 all sectors written 1", q, 1);
      do_read(mkrow(s, 5'h11), mkcol(s, 4'h5), q);
      chk(q == 1'b0, "R6 all sectors written 0", q, 0);
    end
  endtask

  task automatic t_ras_only_exit;
    logic q;
    cbr(1'b1);
    do_read(mkrow(1, 5'h0A), mkcol(1, 4'h3), q);
    chk(q == 1'b0, "R5 re-entry compares", q, 0);
    ras_only(mkrow(0, 5'h03));
    do_read(mkrow(1, 5'h0A), mkcol(1, 4'h3), q);
    chk(q == PAT[1], "R10 row-only refresh exits", q, PAT[1]);
    do_read(mkrow(0, 5'h0A), mkcol(0, 4'h3), q);
    chk(q == PAT[0], "R10 data kept", q, PAT[0]);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_normal();
    t_page();
    t_test_mode();
    t_ras_only_exit();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule